// File: doc/BRIEF.md
# In-Place Register-File Sorter

The block keeps a small bank of unsigned words in registers and puts them in ascending order on request. Before a run, a host stores one word per clock through a write port, choosing the slot with an address. When `start` is raised, a controller walks two nested indices over the bank. An outer index `i` selects a slot whose value is held in a temporary register A. An inner index `j` visits every later slot, copies it into temporary register B, and compares the two. When B is smaller, the two words trade places, and A is refilled from slot `i`. A single comparator and the two temporaries do all of the work.

When the run ends, `done` rises and stays high for as long as `start` is held. During that time the host may read any slot by address, and it may also write new words. Lowering `start` returns the controller to idle, and a new load and sort can then begin. No storage outside the bank is added. The bank has no reset, so its contents are whatever was last written.

Controller states: `ST_IDLE` (host access; a sampled `start` goes to `ST_OUTER`), `ST_OUTER` (A takes slot i, j loads i+1; always goes to `ST_INNER`), `ST_INNER` (B takes slot j; goes to `ST_CMP`), `ST_CMP` (goes to `ST_WR_I` if B < A, otherwise to `ST_STEP`), `ST_WR_I` (slot i takes B; goes to `ST_WR_J`), `ST_WR_J` (slot j takes A; goes to `ST_RELOAD`), `ST_RELOAD` (A takes the new slot i; goes to `ST_STEP`), `ST_STEP` (last j and last i go to `ST_DONE`; last j alone increments i and goes to `ST_OUTER`; otherwise j increments and the state goes to `ST_INNER`), and `ST_DONE` (host access, `done` high; stays there while `start` is high and goes to `ST_IDLE` when `start` is low).

Top module: `regfile_sorter`

## Requirements
- R1: While `rst_n` is low, and after it is released, `done` is low and the controller is idle. Reset is asynchronous and active low. It does not clear the word bank.
- R2: In idle, a rising edge with `wr_en` high stores `data_in` into the slot numbered `addr`. Slot numbers run 0 to ENTRIES-1.
- R3: In idle or done, `data_out` shows slot `addr` in the same cycle while `rd_en` is high. It is all zeros while `rd_en` is low, and all zeros while a run is in progress.
- R4: When `done` rises, slot 0 to slot ENTRIES-1 hold the loaded words in nondecreasing order, as a permutation of the values that were loaded.
- R5: A rising edge in idle that samples `start` high begins a run. The run works on the bank as it stands.
- R6: `done` stays high while `start` is high. On the first rising edge that samples `start` low in the done state, `done` goes low and the controller returns to idle.
- R7: While a run is in progress, `wr_en` has no effect on the bank.
- R8: In the done state, `wr_en` writes the bank as it does in idle.
- R9: With ENTRIES = 4, counting the edge that samples `start` as the first, `done` rises on edge 22 if no exchange is needed. Each exchange adds exactly 3 edges. A strictly decreasing bank takes 40 edges.
- R10: Equal words are never exchanged. A bank whose words are all equal finishes in the no-exchange time.
- R11: A second run on an already ordered bank leaves it unchanged and takes the no-exchange time.
- R12: During a compare, the inner index is greater than the outer index, and the outer index never exceeds ENTRIES-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of controller and indices |
| start | input | 1 | Begins a run in idle; holding it high keeps the done state |
| wr_en | input | 1 | Host write strobe; honoured only in idle or done |
| rd_en | input | 1 | Host read enable for `data_out` |
| addr | input | $clog2(ENTRIES) | Host slot number for reads and writes |
| data_in | input | WIDTH | Word written by the host |
| data_out | output | WIDTH | Word read from slot `addr`, or zero |
| done | output | 1 | High in the done state |

## Verification
A wrong index, a swapped mux select or a lost write enable corrupts the bank. The words read back after `done` then come out of order, or a value appears twice while another goes missing. This shows at the read port as soon as the run ends. Surplus or missing exchange cycles shift the edge on which `done` rises away from the no-exchange baseline plus a multiple of three, so a timing error is visible within one run. The bench checks every 2-bit content of a four-slot bank against a counting sort computed in the bench, and compares each run length with those rules.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OUTER,
        ST_INNER,
        ST_CMP,
        ST_WR_I,
        ST_WR_J,
        ST_RELOAD,
        ST_STEP,
        ST_DONE
    } sort_state_e;

    // control word driven by the controller each cycle
    typedef struct packed {
        logic ext_sel;  // host address drives the bank
        logic init_wr;  // host data drives the write port
        logic bank_wr;  // write the addressed slot
        logic sel_j;    // internal address from j instead of i
        logic sel_b;    // write data from B instead of A
        logic a_en;     // capture read word into A
        logic b_en;     // capture read word into B
        logic i_load;   // clear outer index
        logic i_inc;    // advance outer index
        logic j_load;   // set inner index to i+1
        logic j_inc;    // advance inner index
        logic done;     // run finished
    } sort_ctl_t;

endpackage

// File: rtl/sort_index_ctr.sv
module sort_index_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         inc,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (inc) begin
            q <= q + 1'b1;
        end
    end

endmodule

// File: rtl/sort_regbank.sv
module sort_regbank #(
    parameter int WIDTH   = 8,
    parameter int ENTRIES = 4,
    parameter int AW      = 2
) (
    input  logic                     clk,
    input  logic                     wr,
    input  logic [AW-1:0]            slot,
    input  logic [WIDTH-1:0]         wdata,
    output logic [WIDTH-1:0]         rdata,
    output logic [ENTRIES*WIDTH-1:0] bank_flat
);

    logic [ENTRIES-1:0] slot_we;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic [WIDTH-1:0] word_q;

        // decoder leg, gated by the write strobe
        assign slot_we[e] = wr && (slot == AW'(e));

        always_ff @(posedge clk) begin
            if (slot_we[e]) begin
                word_q <= wdata;
            end
        end

        assign bank_flat[e*WIDTH +: WIDTH] = word_q;
    end

    always_comb begin
        rdata = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (slot == AW'(e)) begin
                rdata = bank_flat[e*WIDTH +: WIDTH];
            end
        end
    end

endmodule

// File: rtl/sort_temp_cmp.sv
module sort_temp_cmp #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             a_en,
    input  logic             b_en,
    input  logic [WIDTH-1:0] rd_word,
    output logic [WIDTH-1:0] a_q,
    output logic [WIDTH-1:0] b_q,
    output logic             b_lt_a
);

    always_ff @(posedge clk) begin
        if (a_en) begin
            a_q <= rd_word;
        end
        if (b_en) begin
            b_q <= rd_word;
        end
    end

    // strict compare: equal words never trade places
    assign b_lt_a = (b_q < a_q);

endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
    import sorter_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int AW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr_en,
    input  logic          b_lt_a,
    input  logic [AW-1:0] i_idx,
    input  logic [AW-1:0] j_idx,
    output sort_state_e   state,
    output sort_ctl_t     ctl
);

    localparam logic [AW-1:0] I_LAST = AW'(ENTRIES - 2);
    localparam logic [AW-1:0] J_LAST = AW'(ENTRIES - 1);

    sort_state_e state_nx;
    logic        j_end;
    logic        i_end;

    assign j_end = (j_idx == J_LAST);
    assign i_end = (i_idx == I_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_OUTER;
            ST_OUTER:  state_nx = ST_INNER;
            ST_INNER:  state_nx = ST_CMP;
            ST_CMP:    state_nx = b_lt_a ? ST_WR_I : ST_STEP;
            ST_WR_I:   state_nx = ST_WR_J;
            ST_WR_J:   state_nx = ST_RELOAD;
            ST_RELOAD: state_nx = ST_STEP;
            ST_STEP: begin
                if (j_end && i_end) begin
                    state_nx = ST_DONE;
                end else if (j_end) begin
                    state_nx = ST_OUTER;
                end else begin
                    state_nx = ST_INNER;
                end
            end
            ST_DONE:   if (!start) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_IDLE: begin
                ctl.ext_sel = 1'b1;
                ctl.init_wr = 1'b1;
                ctl.bank_wr = wr_en;
                ctl.i_load  = 1'b1;
            end
            ST_OUTER: begin
                ctl.a_en   = 1'b1;
                ctl.j_load = 1'b1;
            end
            ST_INNER: begin
                ctl.sel_j = 1'b1;
                ctl.b_en  = 1'b1;
            end
            ST_CMP: begin
                ctl.sel_j = 1'b1;
            end
            ST_WR_I: begin
                ctl.bank_wr = 1'b1;
                ctl.sel_b   = 1'b1;
            end
            ST_WR_J: begin
                ctl.bank_wr = 1'b1;
                ctl.sel_j   = 1'b1;
            end
            ST_RELOAD: begin
                ctl.a_en = 1'b1;
            end
            ST_STEP: begin
                ctl.j_inc = !j_end;
                ctl.i_inc = j_end && !i_end;
            end
            ST_DONE: begin
                ctl.ext_sel = 1'b1;
                ctl.init_wr = 1'b1;
                ctl.bank_wr = wr_en;
                ctl.done    = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/regfile_sorter.sv
module regfile_sorter
    import sorter_pkg::*;
#(
    parameter  int WIDTH   = 8,
    parameter  int ENTRIES = 4,
    localparam int AW      = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] data_out,
    output logic             done
);

    sort_state_e              state;
    sort_ctl_t                ctl;
    logic [AW-1:0]            i_idx;
    logic [AW-1:0]            j_idx;
    logic [AW-1:0]            int_addr;
    logic [AW-1:0]            bank_addr;
    logic [WIDTH-1:0]         wdata;
    logic [WIDTH-1:0]         rdata;
    logic [WIDTH-1:0]         a_q;
    logic [WIDTH-1:0]         b_q;
    logic                     b_lt_a;
    logic                     bank_we;
    logic [ENTRIES*WIDTH-1:0] bank_flat;

    // address and data steering
    assign int_addr  = ctl.sel_j ? j_idx : i_idx;
    assign bank_addr = ctl.ext_sel ? addr : int_addr;
    assign wdata     = ctl.init_wr ? data_in : (ctl.sel_b ? b_q : a_q);
    assign bank_we   = ctl.bank_wr;

    assign data_out = (rd_en && ctl.ext_sel) ? rdata : '0;
    assign done     = ctl.done;

    sort_ctrl #(
        .ENTRIES (ENTRIES),
        .AW      (AW)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .wr_en  (wr_en),
        .b_lt_a (b_lt_a),
        .i_idx  (i_idx),
        .j_idx  (j_idx),
        .state  (state),
        .ctl    (ctl)
    );

    sort_index_ctr #(.W(AW)) u_i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctl.i_load),
        .inc      (ctl.i_inc),
        .load_val ('0),
        .q        (i_idx)
    );

    sort_index_ctr #(.W(AW)) u_j_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctl.j_load),
        .inc      (ctl.j_inc),
        .load_val (AW'(i_idx + 1'b1)),
        .q        (j_idx)
    );

    sort_regbank #(
        .WIDTH   (WIDTH),
        .ENTRIES (ENTRIES),
        .AW      (AW)
    ) u_bank (
        .clk       (clk),
        .wr        (bank_we),
        .slot      (bank_addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .bank_flat (bank_flat)
    );

    sort_temp_cmp #(.WIDTH(WIDTH)) u_temp (
        .clk     (clk),
        .a_en    (ctl.a_en),
        .b_en    (ctl.b_en),
        .rd_word (rdata),
        .a_q     (a_q),
        .b_q     (b_q),
        .b_lt_a  (b_lt_a)
    );

endmodule

// File: rtl/sorter_chk.sv
module sorter_chk
    import sorter_pkg::*;
#(
    parameter  int WIDTH   = 8,
    parameter  int ENTRIES = 4,
    localparam int AW      = $clog2(ENTRIES)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     rd_en,
    input logic                     done,
    input logic [WIDTH-1:0]         data_out,
    input sort_state_e              state,
    input logic [AW-1:0]            i_idx,
    input logic [AW-1:0]            j_idx,
    input logic [WIDTH-1:0]         a_q,
    input logic [WIDTH-1:0]         b_q,
    input logic                     bank_we,
    input logic [ENTRIES*WIDTH-1:0] bank_flat
);

    logic in_order;
    logic busy_no_swap;

    always_comb begin
        in_order = 1'b1;
        for (int e = 0; e < ENTRIES - 1; e++) begin
            if (bank_flat[e*WIDTH +: WIDTH] > bank_flat[(e+1)*WIDTH +: WIDTH]) begin
                in_order = 1'b0;
            end
        end
    end

    assign busy_no_swap = (state == ST_OUTER) || (state == ST_INNER) ||
                          (state == ST_CMP) || (state == ST_RELOAD) ||
                          (state == ST_STEP);

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && start |=> done);

    // R6
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);

    // R3
    quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (data_out == '0));

    // R4
    sorted_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> in_order);

    // R10
    equal_no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMP) && !(b_q < a_q) |=> !bank_we);

    // R7
    busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_no_swap |-> !bank_we);

    // R12
    index_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMP) |-> (j_idx > i_idx) && (int'(i_idx) <= ENTRIES - 2));

endmodule

bind regfile_sorter sorter_chk #(
    .WIDTH   (WIDTH),
    .ENTRIES (ENTRIES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_en     (rd_en),
    .done      (done),
    .data_out  (data_out),
    .state     (state),
    .i_idx     (i_idx),
    .j_idx     (j_idx),
    .a_q       (a_q),
    .b_q       (b_q),
    .bank_we   (bank_we),
    .bank_flat (bank_flat)
);

// File: tb/regfile_sorter_tb.sv
module regfile_sorter_tb;

    localparam int W  = 2;
    localparam int K  = 4;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  data_in = '0;
    logic [W-1:0]  data_out;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    regfile_sorter #(.WIDTH(W), .ENTRIES(K)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .data_in  (data_in),
        .data_out (data_out),
        .done     (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put_word(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1;
        addr = AW'(a);
        data_in = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic get_word(input int a, output int d);
        @(negedge clk);
        rd_en = 1'b1;
        addr = AW'(a);
        #1;
        d = int'(data_out);
        rd_en = 1'b0;
    endtask

    // raise start, count edges to done; poke=1 drives host traffic mid-run
    task automatic run_sort(input bit poke, output int edges);
        edges = 0;
        @(negedge clk);
        start = 1'b1;
        while (edges < 100) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (done) break;
            if (poke) begin
                if (edges >= 3 && edges <= 15) begin
                    wr_en = 1'b1;
                    addr = '0;
                    data_in = W'(3);
                    rd_en = 1'b1;
                    #1;
                    // R3 and R7: no host read data during a run
                    check(data_out == '0, "R3 read during run", int'(data_out), 0);
                end else begin
                    wr_en = 1'b0;
                    rd_en = 1'b0;
                end
            end
        end
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic release_start();
        @(negedge clk);
        // R6: done held while start high
        check(done == 1'b1, "R6 done held", int'(done), 1);
        start = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R6 done released", int'(done), 0);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int edges;
        int vals[K];
        int cnt[4];
        int exp_s[K];
        int got[K];
        bit ordered;
        bit match;
        bit timing_ok;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(data_out == '0, "R3 rd_en low", int'(data_out), 0);

        // R2: store and read back in idle
        put_word(1, 2);
        get_word(1, v);
        check(v == 2, "R2 write slot1", v, 2);
        put_word(2, 3);
        get_word(2, v);
        check(v == 3, "R2 write slot2", v, 3);

        // R4 R5 R9 R10: every content of a 4 x 2-bit bank
        for (int p = 0; p < 256; p++) begin
            for (int e = 0; e < K; e++) vals[e] = (p >> (2 * e)) & 3;
            for (int e = 0; e < K; e++) put_word(e, vals[e]);
            for (int c = 0; c < 4; c++) cnt[c] = 0;
            for (int e = 0; e < K; e++) cnt[vals[e]]++;
            begin
                int pos;
                pos = 0;
                for (int c = 0; c < 4; c++) begin
                    for (int r = 0; r < cnt[c]; r++) begin
                        exp_s[pos] = c;
                        pos++;
                    end
                end
            end
            ordered = 1'b1;
            for (int e = 0; e < K - 1; e++) if (vals[e] > vals[e+1]) ordered = 1'b0;
            run_sort(1'b0, edges);
            match = 1'b1;
            for (int e = 0; e < K; e++) begin
                get_word(e, got[e]);
                if (got[e] != exp_s[e]) match = 1'b0;
            end
            check(match, "R4 sorted contents", got[0]*64 + got[1]*16 + got[2]*4 + got[3],
                  exp_s[0]*64 + exp_s[1]*16 + exp_s[2]*4 + exp_s[3]);
            if (ordered) begin
                // R9 and R10: no exchange, including all-equal banks
                check(edges == 22, "R9 R10 no-exchange time", edges, 22);
            end else begin
                timing_ok = (edges >= 25) && (edges <= 40) && (((edges - 22) % 3) == 0);
                check(timing_ok, "R9 exchange time", edges, 25);
            end
            if (p == 8'b00_01_10_11) begin
                check(edges == 40, "R9 decreasing bank", edges, 40);
            end
            release_start();
        end

        // R7: host writes during a run are ignored
        put_word(0, 3); put_word(1, 1); put_word(2, 2); put_word(3, 0);
        run_sort(1'b1, edges);
        match = 1'b1;
        for (int e = 0; e < K; e++) begin
            get_word(e, got[e]);
            if (got[e] != e) match = 1'b0;
        end
        check(match, "R7 writes ignored", got[0]*64 + got[1]*16 + got[2]*4 + got[3], 27);

        // R8: write accepted in done state
        put_word(2, 1);
        get_word(2, v);
        check(v == 1, "R8 write in done", v, 1);
        check(done == 1'b1, "R8 still done", int'(done), 1);
        release_start();

        // R11: rerun on an ordered bank
        put_word(2, 2);
        run_sort(1'b0, edges);
        check(edges == 22, "R11 rerun time", edges, 22);
        match = 1'b1;
        for (int e = 0; e < K; e++) begin
            get_word(e, got[e]);
            if (got[e] != e) match = 1'b0;
        end
        check(match, "R11 rerun unchanged", got[0]*64 + got[1]*16 + got[2]*4 + got[3], 27);
        release_start();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule